// File: doc/BRIEF.md
# Fine Frequency Trim Unit

This block computes a new period increment for a time-of-day counter from a base increment and a signed frequency offset. The offset is in parts per million, carried with 16 fractional bits. The base increment has a whole-nanosecond field and a fraction field, and the two are packed into one word. The unit multiplies the offset magnitude by that word and adds a rounding constant. It drops the fractional ppm bits and divides by one million with a restoring divider that produces one quotient bit per clock. It then adds the quotient to the base word, or subtracts it when the offset was negative.

A caller pulses `start_i` with the offset and base fields on the inputs. A single-cycle `done_o` strobe marks the moment the new whole and fraction fields are valid. The fields then hold until the next strobe. A start pulse that arrives during a computation is dropped.

Top module: `freq_trim_unit`

## Requirements
- R1: After reset, `done_o` is low and `inc_ns_o` and `inc_frac_o` are zero.
- R2: A negative offset (bit 31 set, two's complement) is used through its magnitude, and the adjustment is subtracted. A zero or positive offset is added. The most negative offset 0x80000000 has magnitude 2^31.
- R3: The base word is `{base_ns_i, base_frac_i}`, with the 8 whole-nanosecond bits above the 24 fraction bits.
- R4: The adjustment is floor(((|offset| * word) + 500000) / 2^16 / 1000000). The rounding constant is added before the 16-bit shift, and the product is kept at full 64-bit width plus one carry bit.
- R5: The result is (word ± adjustment) modulo 2^32. `inc_ns_o` is result bits 31:24 and `inc_frac_o` is result bits 23:0.
- R6: `done_o` is high for exactly one cycle, 51 clock edges after the edge that accepts `start_i` with default parameters. That count is the quotient width (64 + 1 - 16 = 49) plus 2.
- R7: A start pulse while a computation is in flight is ignored, together with its offset and base values. The running result is unaffected, and no extra strobe follows.
- R8: An offset of zero returns the base increment unchanged.
- R9: `inc_ns_o` and `inc_frac_o` hold their value between strobes, including while a later computation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| offset_i | input | 32 | Signed offset, ppm with 16 fractional bits |
| base_ns_i | input | 8 | Base increment whole nanoseconds |
| base_frac_i | input | 24 | Base increment fraction |
| done_o | output | 1 | One-cycle result strobe |
| inc_ns_o | output | 8 | New increment whole nanoseconds |
| inc_frac_o | output | 24 | New increment fraction |

## Verification
The bench builds the unit with its default widths: a 32-bit offset, an 8.24 increment and a 16-bit ppm fraction. This gives a 49-bit dividend and a fixed 51-cycle latency that every operation checks. With these widths, extreme operands are reachable: an offset of 0x80000000 exercises the magnitude corner. Full-scale positive offsets on an all-ones base push the sum past 2^32 and show the modulo wrap. Small offsets on round bases expose whether the half-million constant is added before the shift.

// File: rtl/ftu_pkg.sv
package ftu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCALE = 2'd1,
    ST_DIV   = 2'd2
  } ftu_state_e;
endpackage

// File: rtl/ftu_capture.sv
module ftu_capture #(
  parameter int OFF_W  = 32,
  parameter int NS_W   = 8,
  parameter int FRAC_W = 24,
  localparam int INC_W = NS_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OFF_W-1:0]  offset,
  input  logic [NS_W-1:0]   base_ns,
  input  logic [FRAC_W-1:0] base_frac,
  output logic [OFF_W-1:0]  mag,
  output logic              neg,
  output logic [INC_W-1:0]  word
);
  logic [OFF_W-1:0] mag_d;
  logic             neg_d;
  logic [INC_W-1:0] word_d;

  always_comb begin
    neg_d  = offset[OFF_W-1];
    mag_d  = neg_d ? (~offset + OFF_W'(1)) : offset;
    word_d = {base_ns, base_frac};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag  <= '0;
      neg  <= 1'b0;
      word <= '0;
    end else if (load) begin
      mag  <= mag_d;
      neg  <= neg_d;
      word <= word_d;
    end
  end
endmodule

// File: rtl/ftu_scale.sv
module ftu_scale #(
  parameter int OFF_W      = 32,
  parameter int INC_W      = 32,
  parameter int PPM_FRAC_W = 16,
  parameter int MILLION    = 1000000,
  localparam int PROD_W = OFF_W + INC_W,
  localparam int SUM_W  = PROD_W + 1,
  localparam int QW     = SUM_W - PPM_FRAC_W
) (
  input  logic [OFF_W-1:0] mag,
  input  logic [INC_W-1:0] word,
  output logic [QW-1:0]    dividend
);
  localparam int HALF = MILLION / 2;

  logic [PROD_W-1:0] prod;
  logic [SUM_W-1:0]  sum;
  logic              unused_low;

  always_comb begin
    prod     = PROD_W'(mag) * PROD_W'(word);
    sum      = SUM_W'(prod) + SUM_W'(HALF);
    dividend = sum[SUM_W-1:PPM_FRAC_W];
  end

  assign unused_low = ^sum[PPM_FRAC_W-1:0];
endmodule

// File: rtl/ftu_rdiv.sv
module ftu_rdiv #(
  parameter int QW      = 49,
  parameter int RES_W   = 32,
  parameter int DIVISOR = 1000000,
  localparam int DV_W = $clog2(DIVISOR),
  localparam int CW   = $clog2(QW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [QW-1:0]    dividend,
  output logic [RES_W-1:0] quotient,
  output logic             fin
);
  localparam logic [DV_W:0] DIV_C = (DV_W + 1)'(DIVISOR);

  logic [QW-1:0]    dvd_q, dvd_d;
  logic [RES_W-1:0] quo_q, quo_d;
  logic [DV_W-1:0]  rem_q, rem_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             fin_q, fin_d;
  logic [DV_W:0]    trial, diff;
  logic             ge;

  always_comb begin
    trial = {rem_q, dvd_q[QW-1]};
    ge    = (trial >= DIV_C);
    diff  = trial - DIV_C;
    dvd_d = dvd_q;
    quo_d = quo_q;
    rem_d = rem_q;
    cnt_d = cnt_q;
    fin_d = 1'b0;
    if (load) begin
      dvd_d = dividend;
      quo_d = '0;
      rem_d = '0;
      cnt_d = CW'(QW);
    end else if (cnt_q != '0) begin
      dvd_d = {dvd_q[QW-2:0], 1'b0};
      quo_d = {quo_q[RES_W-2:0], ge};
      rem_d = ge ? diff[DV_W-1:0] : trial[DV_W-1:0];
      cnt_d = cnt_q - CW'(1);
      fin_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q <= '0;
      quo_q <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      dvd_q <= dvd_d;
      quo_q <= quo_d;
      rem_q <= rem_d;
      cnt_q <= cnt_d;
      fin_q <= fin_d;
    end
  end

  assign quotient = quo_q;
  assign fin      = fin_q;

  // R4: the partial remainder of a restoring divide stays below the divisor
  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q < DIVISOR));

  // R6: completion marker lasts one cycle
  assert_fin_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);
endmodule

// File: rtl/ftu_apply.sv
module ftu_apply #(
  parameter int NS_W   = 8,
  parameter int FRAC_W = 24,
  localparam int INC_W = NS_W + FRAC_W
) (
  input  logic [INC_W-1:0]  word,
  input  logic [INC_W-1:0]  adj,
  input  logic              neg,
  output logic [NS_W-1:0]   res_ns,
  output logic [FRAC_W-1:0] res_frac
);
  logic [INC_W-1:0] res;

  always_comb begin
    res      = neg ? (word - adj) : (word + adj);
    res_ns   = res[INC_W-1:FRAC_W];
    res_frac = res[FRAC_W-1:0];
  end
endmodule

// File: rtl/freq_trim_unit.sv
module freq_trim_unit
  import ftu_pkg::*;
#(
  parameter int OFF_W      = 32,
  parameter int NS_W       = 8,
  parameter int FRAC_W     = 24,
  parameter int PPM_FRAC_W = 16,
  parameter int MILLION    = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [NS_W-1:0]   base_ns_i,
  input  logic [FRAC_W-1:0] base_frac_i,
  output logic              done_o,
  output logic [NS_W-1:0]   inc_ns_o,
  output logic [FRAC_W-1:0] inc_frac_o
);
  localparam int INC_W = NS_W + FRAC_W;
  localparam int QW    = OFF_W + INC_W + 1 - PPM_FRAC_W;

  ftu_state_e       state_q, state_d;
  logic             accept;
  logic [OFF_W-1:0] mag_q;
  logic             neg_q;
  logic [INC_W-1:0] word_q;
  logic [QW-1:0]    dividend;
  logic [INC_W-1:0] adj;
  logic             div_fin;
  logic [NS_W-1:0]  res_ns;
  logic [FRAC_W-1:0] res_frac;
  logic             out_en;
  logic             done_q, done_d;
  logic [NS_W-1:0]  ns_q;
  logic [FRAC_W-1:0] frac_q;

  assign accept = (state_q == ST_IDLE) && start_i;

  ftu_capture #(.OFF_W(OFF_W), .NS_W(NS_W), .FRAC_W(FRAC_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .offset(offset_i),
    .base_ns(base_ns_i), .base_frac(base_frac_i),
    .mag(mag_q), .neg(neg_q), .word(word_q)
  );

  ftu_scale #(.OFF_W(OFF_W), .INC_W(INC_W), .PPM_FRAC_W(PPM_FRAC_W),
              .MILLION(MILLION)) scale_i (
    .mag(mag_q), .word(word_q), .dividend(dividend)
  );

  ftu_rdiv #(.QW(QW), .RES_W(INC_W), .DIVISOR(MILLION)) div_i (
    .clk(clk), .rst_n(rst_n), .load(state_q == ST_SCALE),
    .dividend(dividend), .quotient(adj), .fin(div_fin)
  );

  ftu_apply #(.NS_W(NS_W), .FRAC_W(FRAC_W)) apply_i (
    .word(word_q), .adj(adj), .neg(neg_q),
    .res_ns(res_ns), .res_frac(res_frac)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_SCALE;
      ST_SCALE: state_d = ST_DIV;
      ST_DIV:   if (div_fin) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    out_en = (state_q == ST_DIV) && div_fin;
    done_d = out_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (out_en) begin
      ns_q   <= res_ns;
      frac_q <= res_frac;
    end
  end

  assign done_o     = done_q;
  assign inc_ns_o   = ns_q;
  assign inc_frac_o = frac_q;

  // R6: the result strobe is a single cycle wide
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: a start seen while busy leaves the captured operands untouched
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i) |=> ($stable(mag_q) && $stable(word_q)));

  // R8: a zero offset yields the base word on the outputs
  assert_zero_identity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mag_q == '0) |-> ({ns_q, frac_q} == word_q));

  // R9: outputs only move together with a strobe
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_d |=> ($stable(ns_q) && $stable(frac_q)));
endmodule

// File: tb/freq_trim_unit_tb_top.sv
module freq_trim_unit_tb_top;
  localparam int LAT = 51;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] offset_i;
  logic [7:0]  base_ns_i;
  logic [23:0] base_frac_i;
  logic        done_o;
  logic [7:0]  inc_ns_o;
  logic [23:0] inc_frac_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  freq_trim_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
    .base_ns_i(base_ns_i), .base_frac_i(base_frac_i),
    .done_o(done_o), .inc_ns_o(inc_ns_o), .inc_frac_o(inc_frac_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] off, input logic [7:0] ns,
                                        input logic [23:0] fr);
    logic [31:0] m, w, r;
    logic [64:0] p;
    m = off[31] ? (~off + 32'd1) : off;
    w = {ns, fr};
    p = {33'd0, m} * {33'd0, w};
    p = p + 65'd500000;
    p = p >> 16;
    p = p / 65'd1000000;
    r = off[31] ? (w - p[31:0]) : (w + p[31:0]);
    return r;
  endfunction

  task automatic pulse_start(input logic [31:0] off, input logic [7:0] ns, input logic [23:0] fr);
    @(negedge clk);
    start_i = 1'b1; offset_i = off; base_ns_i = ns; base_frac_i = fr;
    @(negedge clk);
    start_i = 1'b0; offset_i = $urandom; base_ns_i = $urandom; base_frac_i = $urandom;
  endtask

  // start accepted at a posedge; count edges until done is seen
  task automatic run_op(input string req, input logic [31:0] off, input logic [7:0] ns,
                        input logic [23:0] fr);
    logic [31:0] exp;
    int n;
    exp = model(off, ns, fr);
    @(negedge clk);
    start_i = 1'b1; offset_i = off; base_ns_i = ns; base_frac_i = fr;
    @(posedge clk); #1;
    start_i = 1'b0; offset_i = $urandom; base_ns_i = $urandom; base_frac_i = $urandom;
    n = 0;
    while (!done_o && n < 200) begin
      @(posedge clk); #1; n++;
    end
    check({"R6 latency ", req}, 64'(n), 64'(LAT));
    check({req, " ns field R5"}, 64'(inc_ns_o), 64'(exp[31:24]));
    check({req, " frac field R5"}, 64'(inc_frac_o), 64'(exp[23:0]));
    @(posedge clk); #1;
    check({"R6 strobe width ", req}, 64'(done_o), 64'd0);
  endtask

  task automatic t_reset();
    check("R1 done after reset", 64'(done_o), 64'd0);
    check("R1 ns after reset", 64'(inc_ns_o), 64'd0);
    check("R1 frac after reset", 64'(inc_frac_o), 64'd0);
  endtask

  task automatic t_positive();
    run_op("R2 R3 R4 +1ppm on 8ns", 32'h0001_0000, 8'd8, 24'd0);
    run_op("R4 rounding 2.5ppm", 32'h0002_8000, 8'd6, 24'h555555);
  endtask

  task automatic t_negative();
    run_op("R2 -1.5ppm", 32'hFFFE_8000, 8'd8, 24'h000100);
    run_op("R2 most negative", 32'h8000_0000, 8'd1, 24'd0);
  endtask

  task automatic t_zero();
    run_op("R8 zero offset", 32'd0, 8'd7, 24'hABCDEF);
    check("R8 identity ns", 64'(inc_ns_o), 64'd7);
    check("R8 identity frac", 64'(inc_frac_o), 64'hABCDEF);
  endtask

  task automatic t_wrap();
    run_op("R5 wrap full scale", 32'h7FFF_FFFF, 8'hFF, 24'hFFFFFF);
    run_op("R3 field order", 32'h0064_0000, 8'h00, 24'hFFFFFF);
  endtask

  task automatic t_ignore();
    logic [31:0] exp;
    int n;
    int extra;
    exp = model(32'h0010_0000, 8'd40, 24'h123456);
    @(negedge clk);
    start_i = 1'b1; offset_i = 32'h0010_0000; base_ns_i = 8'd40; base_frac_i = 24'h123456;
    @(posedge clk); #1;
    start_i = 1'b0;
    n = 0;
    repeat (5) begin @(posedge clk); #1; n++; end
    @(negedge clk);
    start_i = 1'b1; offset_i = 32'hFFF0_0000; base_ns_i = 8'd3; base_frac_i = 24'd9;
    @(posedge clk); #1; n++;
    start_i = 1'b0;
    while (!done_o && n < 200) begin
      @(posedge clk); #1; n++;
    end
    check("R7 latency unchanged", 64'(n), 64'(LAT));
    check("R7 ns from first op", 64'(inc_ns_o), 64'(exp[31:24]));
    check("R7 frac from first op", 64'(inc_frac_o), 64'(exp[23:0]));
    extra = 0;
    for (int i = 0; i < 80; i++) begin
      @(posedge clk); #1;
      if (done_o) extra++;
    end
    check("R7 no extra strobe", 64'(extra), 64'd0);
    check("R9 ns held", 64'(inc_ns_o), 64'(exp[31:24]));
    check("R9 frac held", 64'(inc_frac_o), 64'(exp[23:0]));
  endtask

  task automatic t_hold_during_run();
    logic [7:0]  ns0;
    logic [23:0] fr0;
    ns0 = inc_ns_o; fr0 = inc_frac_o;
    pulse_start(32'h0200_0000, 8'd2, 24'd77);
    repeat (20) @(posedge clk);
    #1;
    check("R9 ns held while busy", 64'(inc_ns_o), 64'(ns0));
    check("R9 frac held while busy", 64'(inc_frac_o), 64'(fr0));
    repeat (LAT) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; offset_i = '0; base_ns_i = '0; base_frac_i = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    t_positive();
    t_negative();
    t_zero();
    t_wrap();
    t_ignore();
    t_hold_during_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule